// File: doc/BRIEF.md
# Paged Monochrome LCD Frame Buffer

This block holds the picture for a 128 x 64 one-bit display and fills it from a processor bus. Memory is arranged as eight pages of 128 bytes. Each page is a horizontal band eight pixel rows tall, and each byte in it is one column of that band. Software first chooses a write mode by storing one of two exact 32-bit code words in a mode register. It then sends page-select commands and pixel bytes. A page select puts the column pointer at the start of the chosen page. Each pixel byte goes to the current column, and the pointer then steps to the next column, wrapping inside the page.

The one data register does two jobs. In command mode a value written to it is read as a page-select command. In data mode it is stored as a pixel byte. In any other mode the write has no effect. There is also a dedicated instruction register that accepts page selects in every mode. A separate read-only scan port, used by the display refresh logic, returns a single pixel bit for an (x, y) coordinate. Bus traffic does not stall it. A 32-bit interrupt-control word can be read and written. Every other register offset reads as zero.

Top module: `lcd_page_fb`

## Requirements
- R1: After reset the interrupt-control word is 0, the write mode is invalid, the cursor is at page 0 column 0, and every pixel reads 0.
- R2: A write to offset 0x180 stores all 32 bits of the interrupt-control word. A read of 0x180 returns that word on rdata_o one clock after the read request.
- R3: A read of any offset other than 0x180 returns 0, and that includes the mode, instruction and data registers.
- R4: A write to the mode offset 0x1AC sets data mode only for 0x00100011 and command mode only for 0x00104011. Any other value sets the invalid mode.
- R5: A write to the instruction offset 0x1BC with a value from 0xB0 to 0xB7 selects page (value - 0xB0) and sets the column to 0. Any other value leaves the page and the column unchanged.
- R6: In command mode, a write to the data offset 0x1C0 follows the same page-select rule as R5 and never changes a pixel.
- R7: In data mode, a write to 0x1C0 stores wdata_i[7:0] at byte index page*128 + column. The column then advances by one, going from 127 back to 0 on the same page.
- R8: While the mode is invalid, a write to 0x1C0 changes neither pixels, page nor column.
- R9: scan_pix_o, one clock after scan_x_i and scan_y_i are applied, equals bit (y mod 8) of byte index x + (y / 8)*128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| scan_x_i | input | 7 | Scan column |
| scan_y_i | input | 6 | Scan row |
| scan_pix_o | output | 1 | Pixel bit, one cycle after the coordinate |

## Verification
The hardest state to reach from the ports is the column wrap. The cursor cannot be read, so the wrap only shows up when a run of more than 128 data-mode bytes overwrites the first columns of the same page and leaves the next page untouched. A directed burst of 130 bytes produces this, and the scan port then reads back the overwritten columns and the neighbouring page. Page selects sent through the data register in command mode are mixed with near-miss mode words and out-of-range commands. Random operation sequences from a fixed seed then run against a bench model, and a full scan of all 8192 pixels compares the whole buffer with that model.

// File: rtl/lcd_fb_pkg.sv
package lcd_fb_pkg;
  localparam int unsigned REG_ADDR_W = 12;
  localparam int unsigned REG_DATA_W = 32;

  localparam logic [REG_ADDR_W-1:0] OFF_IRQ_CTL = 12'h180;
  localparam logic [REG_ADDR_W-1:0] OFF_MODE    = 12'h1AC;
  localparam logic [REG_ADDR_W-1:0] OFF_INST    = 12'h1BC;
  localparam logic [REG_ADDR_W-1:0] OFF_DATA    = 12'h1C0;

  localparam logic [REG_DATA_W-1:0] CODE_DATA_MODE = 32'h0010_0011;
  localparam logic [REG_DATA_W-1:0] CODE_CMD_MODE  = 32'h0010_4011;
  localparam logic [REG_DATA_W-1:0] PAGE_CMD_BASE  = 32'h0000_00B0;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DATA = 2'd1,
    MODE_CMD  = 2'd2
  } wr_mode_e;
endpackage

// File: rtl/lcd_fb_regs.sv
module lcd_fb_regs
  import lcd_fb_pkg::*;
#(
  parameter int unsigned PAGES = 8,
  localparam int unsigned PG_W = $clog2(PAGES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [REG_DATA_W-1:0] wdata_i,
  output logic [REG_DATA_W-1:0] rdata_o,
  output logic                  sel_vld_o,
  output logic [PG_W-1:0]       sel_page_o,
  output logic                  px_wr_o,
  output logic [7:0]            px_byte_o
);
  localparam logic [REG_DATA_W-1:0] PAGE_CMD_LAST = PAGE_CMD_BASE + REG_DATA_W'(PAGES - 1);

  wr_mode_e              mode_q;
  logic [REG_DATA_W-1:0] irq_ctl_q;
  logic                  wr_irq, wr_mode, wr_inst, wr_data, is_page_cmd;
  logic [REG_DATA_W-1:0] page_ofs;

  assign wr_irq  = wr_en_i && (addr_i == OFF_IRQ_CTL);
  assign wr_mode = wr_en_i && (addr_i == OFF_MODE);
  assign wr_inst = wr_en_i && (addr_i == OFF_INST);
  assign wr_data = wr_en_i && (addr_i == OFF_DATA);

  assign is_page_cmd = (wdata_i >= PAGE_CMD_BASE) && (wdata_i <= PAGE_CMD_LAST);
  assign page_ofs    = wdata_i - PAGE_CMD_BASE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
    end else if (wr_mode) begin
      if (wdata_i == CODE_DATA_MODE)     mode_q <= MODE_DATA;
      else if (wdata_i == CODE_CMD_MODE) mode_q <= MODE_CMD;
      else                               mode_q <= MODE_OFF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_ctl_q <= '0;
    else if (wr_irq) irq_ctl_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  rdata_o <= '0;
    else if (rd_en_i && addr_i == OFF_IRQ_CTL)    rdata_o <= irq_ctl_q;
    else                                          rdata_o <= '0;
  end

  always_comb begin
    sel_vld_o  = is_page_cmd && (wr_inst || (wr_data && mode_q == MODE_CMD));
    sel_page_o = page_ofs[PG_W-1:0];
    px_wr_o    = wr_data && (mode_q == MODE_DATA);
    px_byte_o  = wdata_i[7:0];
  end

  a_r4_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q inside {MODE_OFF, MODE_DATA, MODE_CMD});
  a_r3_other_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i != OFF_IRQ_CTL |=> rdata_o == '0);
  a_r2_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_irq |=> $stable(irq_ctl_q));
  a_r8_off_no_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_OFF |-> !px_wr_o);
  a_r6_cmd_no_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_vld_o && px_wr_o));
endmodule

// File: rtl/lcd_fb_cursor.sv
module lcd_fb_cursor #(
  parameter int unsigned COLS  = 128,
  parameter int unsigned PAGES = 8,
  localparam int unsigned X_W  = $clog2(COLS),
  localparam int unsigned PG_W = $clog2(PAGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_vld_i,
  input  logic [PG_W-1:0] sel_page_i,
  input  logic            px_wr_i,
  output logic [PG_W-1:0] page_o,
  output logic [X_W-1:0]  col_o
);
  localparam logic [X_W-1:0] COL_LAST = X_W'(COLS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      col_o  <= '0;
    end else if (sel_vld_i) begin
      page_o <= sel_page_i;
      col_o  <= '0;
    end else if (px_wr_i) begin
      col_o  <= (col_o == COL_LAST) ? '0 : col_o + 1'b1;
    end
  end

  a_r5_sel_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_vld_i |=> col_o == '0 && page_o == $past(sel_page_i));
  a_r7_col_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_wr_i && !sel_vld_i && col_o == COL_LAST |=> col_o == '0 && $stable(page_o));
  a_r8_cursor_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_vld_i && !px_wr_i |=> $stable(col_o) && $stable(page_o));
endmodule

// File: rtl/lcd_fb_mem.sv
module lcd_fb_mem #(
  parameter int unsigned COLS  = 128,
  parameter int unsigned PAGES = 8,
  localparam int unsigned X_W   = $clog2(COLS),
  localparam int unsigned PG_W  = $clog2(PAGES),
  localparam int unsigned Y_W   = PG_W + 3,
  localparam int unsigned DEPTH = COLS * PAGES,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [PG_W-1:0] wr_page_i,
  input  logic [X_W-1:0]  wr_col_i,
  input  logic [7:0]      wr_byte_i,
  input  logic [X_W-1:0]  scan_x_i,
  input  logic [Y_W-1:0]  scan_y_i,
  output logic            scan_pix_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       rd_byte;

  assign wr_idx  = IDX_W'(wr_page_i) * IDX_W'(COLS) + IDX_W'(wr_col_i);
  assign rd_idx  = IDX_W'(scan_y_i[Y_W-1:3]) * IDX_W'(COLS) + IDX_W'(scan_x_i);
  assign rd_byte = mem_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx] <= wr_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scan_pix_o <= 1'b0;
    else         scan_pix_o <= rd_byte[scan_y_i[2:0]];
  end
endmodule

// File: rtl/lcd_page_fb.sv
module lcd_page_fb
  import lcd_fb_pkg::*;
#(
  parameter int unsigned COLS  = 128,
  parameter int unsigned PAGES = 8,
  localparam int unsigned X_W  = $clog2(COLS),
  localparam int unsigned PG_W = $clog2(PAGES),
  localparam int unsigned Y_W  = PG_W + 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [REG_DATA_W-1:0] wdata_i,
  output logic [REG_DATA_W-1:0] rdata_o,
  input  logic [X_W-1:0]        scan_x_i,
  input  logic [Y_W-1:0]        scan_y_i,
  output logic                  scan_pix_o
);
  logic            sel_vld, px_wr;
  logic [PG_W-1:0] sel_page, cur_page;
  logic [X_W-1:0]  cur_col;
  logic [7:0]      px_byte;

  lcd_fb_regs #(.PAGES(PAGES)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .sel_vld_o(sel_vld), .sel_page_o(sel_page), .px_wr_o(px_wr), .px_byte_o(px_byte)
  );

  lcd_fb_cursor #(.COLS(COLS), .PAGES(PAGES)) u_cursor (
    .clk_i, .rst_ni, .sel_vld_i(sel_vld), .sel_page_i(sel_page), .px_wr_i(px_wr),
    .page_o(cur_page), .col_o(cur_col)
  );

  lcd_fb_mem #(.COLS(COLS), .PAGES(PAGES)) u_mem (
    .clk_i, .rst_ni, .wr_en_i(px_wr), .wr_page_i(cur_page), .wr_col_i(cur_col),
    .wr_byte_i(px_byte), .scan_x_i, .scan_y_i, .scan_pix_o
  );
endmodule

// File: tb/lcd_page_fb_test.sv
module lcd_page_fb_test;
  localparam logic [11:0] A_IRQ = 12'h180, A_MODE = 12'h1AC, A_INST = 12'h1BC, A_DATA = 12'h1C0;
  localparam logic [31:0] M_DATA = 32'h0010_0011, M_CMD = 32'h0010_4011;

  logic        clk_i = 0, rst_ni = 0, wr_en_i = 0, rd_en_i = 0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [6:0]  scan_x_i = '0;
  logic [5:0]  scan_y_i = '0;
  logic        scan_pix_o;

  int checks = 0, errors = 0;
  logic [7:0]  exp_mem [1024];
  int          exp_page = 0, exp_col = 0, exp_mode = 0;
  logic [31:0] exp_irq = '0;

  lcd_page_fb uut (.*);

  always #10ns clk_i = ~clk_i;

  initial begin
    #(20ns * 190000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic bit is_sel(logic [31:0] v);
    return v >= 32'hB0 && v <= 32'hB7;
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] v);
    case (a)
      A_IRQ:  exp_irq = v;
      A_MODE: exp_mode = (v == M_DATA) ? 1 : (v == M_CMD) ? 2 : 0;
      A_INST: if (is_sel(v)) begin exp_page = int'(v - 32'hB0); exp_col = 0; end
      A_DATA: begin
        if (exp_mode == 2 && is_sel(v)) begin exp_page = int'(v - 32'hB0); exp_col = 0; end
        else if (exp_mode == 1) begin
          exp_mem[exp_page * 128 + exp_col] = v[7:0];
          exp_col = (exp_col + 1) % 128;
        end
      end
      default: ;
    endcase
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] v);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = a; wdata_i = v;
    @(negedge clk_i);
    wr_en_i = 0;
    model_write(a, v);
  endtask

  task automatic bus_read(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk_i);
    rd_en_i = 1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 0;
    checks++;
    if (rdata_o !== exp) begin
      errors++;
      $display("FAIL %s read 0x%h: actual 0x%h expected 0x%h", req, a, rdata_o, exp);
    end
  endtask

  task automatic scan_check(int x, int y, string req);
    logic exp;
    @(negedge clk_i);
    scan_x_i = 7'(x); scan_y_i = 6'(y);
    @(negedge clk_i);
    exp = exp_mem[x + (y / 8) * 128][y % 8];
    checks++;
    if (scan_pix_o !== exp) begin
      errors++;
      $display("FAIL %s pixel (%0d,%0d): actual %b expected %b", req, x, y, scan_pix_o, exp);
    end
  endtask

  task automatic byte_check(int page, int col, string req);
    for (int b = 0; b < 8; b++) scan_check(col, page * 8 + b, req);
  endtask

  initial begin
    int unsigned r;
    for (int i = 0; i < 1024; i++) exp_mem[i] = '0;
    r = $urandom(32'h5EED_1CD0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    bus_read(A_IRQ, 32'h0, "R1");
    scan_check(0, 0, "R1");
    scan_check(127, 63, "R1");
    // R8: invalid mode after reset, data write ignored
    bus_write(A_DATA, 32'hFF);
    scan_check(0, 0, "R8");
    scan_check(0, 7, "R8");

    // R2 interrupt control
    bus_write(A_IRQ, 32'hDEAD_BEEF);
    bus_read(A_IRQ, 32'hDEAD_BEEF, "R2");
    bus_write(A_IRQ, 32'h0000_0005);
    bus_read(A_IRQ, 32'h0000_0005, "R2");

    // R3 other offsets read zero
    bus_write(A_MODE, M_DATA);
    bus_read(A_MODE, 32'h0, "R3");
    bus_read(A_INST, 32'h0, "R3");
    bus_read(A_DATA, 32'h0, "R3");
    bus_read(12'h000, 32'h0, "R3");

    // R7 burst of 130 bytes on page 0: wrap overwrites columns 0 and 1
    for (int i = 0; i < 130; i++) bus_write(A_DATA, 32'(i + 8'h11));
    byte_check(0, 0, "R7");
    byte_check(0, 1, "R7");
    byte_check(0, 2, "R7");
    byte_check(0, 127, "R7");
    byte_check(1, 0, "R7");

    // R6 page select through data register in command mode
    bus_write(A_MODE, M_CMD);
    bus_write(A_DATA, 32'hB3);
    bus_write(A_DATA, 32'hC0);          // not a page select: ignored
    bus_write(A_DATA, 32'h1_00B5);      // upper bits set: ignored
    bus_write(A_MODE, M_DATA);
    bus_write(A_DATA, 32'hA5);
    bus_write(A_DATA, 32'h3C);
    byte_check(3, 0, "R6");
    byte_check(3, 1, "R6");
    byte_check(5, 0, "R6");

    // R5 instruction register, valid and ignored values
    bus_write(A_INST, 32'hB7);
    bus_write(A_INST, 32'hAF);
    bus_write(A_INST, 32'hB8);
    bus_write(A_DATA, 32'h81);
    byte_check(7, 0, "R5");
    bus_write(A_INST, 32'hB3);
    bus_write(A_DATA, 32'h7E);
    byte_check(3, 0, "R5");

    // R4 near-miss mode words give invalid mode
    bus_write(A_MODE, 32'h0010_0010);
    bus_write(A_DATA, 32'hFF);
    byte_check(3, 1, "R4");
    bus_write(A_MODE, 32'h0010_4010);
    bus_write(A_DATA, 32'hB6);
    bus_write(A_MODE, M_DATA);
    bus_write(A_DATA, 32'h99);
    byte_check(3, 1, "R4");
    byte_check(6, 0, "R4");

    // randomized mixture
    for (int n = 0; n < 1500; n++) begin
      int k;
      logic [31:0] v;
      k = int'($urandom_range(0, 9));
      case (k)
        0: begin
          r = $urandom_range(0, 3);
          v = (r == 0) ? M_CMD : (r == 3) ? $urandom() : M_DATA;
          bus_write(A_MODE, v);
        end
        1: bus_write(A_INST, ($urandom_range(0, 3) == 0) ? $urandom() : 32'($urandom_range(32'hAE, 32'hB9)));
        2: bus_write(A_IRQ, $urandom());
        3: scan_check(int'($urandom_range(0, 127)), int'($urandom_range(0, 63)), "R9");
        default: begin
          v = (exp_mode == 2) ? 32'($urandom_range(32'hAE, 32'hB9)) : $urandom();
          bus_write(A_DATA, v);
        end
      endcase
    end
    bus_read(A_IRQ, exp_irq, "R2");

    // R9 full scan
    for (int y = 0; y < 64; y++)
      for (int x = 0; x < 128; x++) scan_check(x, y, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule